// File: doc/BRIEF.md
# SPI Master Interrupt Status and Mask Unit

This unit gathers the interrupt sources of an SPI master that moves bytes through a transmit FIFO and a receive FIFO. Three sources are events that latch: transmit underflow, receive overflow and mode fail. Four are live conditions taken from the FIFOs on every cycle: receive full, transmit full, a receive level at or above a programmable watermark, and a transmit level below a second programmable watermark. The unit combines these into a 7-bit status word. It keeps a 7-bit mask and drives one level-sensitive interrupt line.

Software uses a small register port with one write strobe, an address, write data and combinational read data. The mask is never written directly. One address ORs bits into it and another removes bits from it. Latched events are cleared by writing ones to the status address. The FIFO occupancy counts and full flags come from the surrounding controller.

Top module: `spi_irq_regs`

## Requirements
- R1: The status word read at address 0 has, from bit 6 down to bit 0: transmit underflow, receive full, receive watermark reached, transmit full, transmit below watermark, mode fail, receive overflow. Read bit 7 is 0.
- R2: A one-cycle pulse on `ev_tx_underflow`, `ev_mode_fail` or `ev_rx_overflow` sets status bit 6, 1 or 0, respectively, from the next cycle on. The bit stays set until a write to address 0 with a 1 in that bit position. Writing 0 there has no effect.
- R3: If an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the bit is set after that cycle.
- R4: Status bit 4 is 1 exactly when `rx_count` is greater than or equal to the receive watermark. A watermark of 0 keeps the bit at 1.
- R5: Status bit 2 is 1 exactly when `tx_count` is strictly less than the transmit watermark. A watermark of 0 keeps the bit at 0.
- R6: Status bits 5 and 3 follow `rx_full` and `tx_full` in the same cycle. Writing ones to address 0 does not change them.
- R7: A write to address 1 ORs `reg_wdata[6:0]` into the mask. A write to address 2 clears the mask bits set in `reg_wdata[6:0]`. The mask reads at address 3, and writes to address 3 are ignored. Addresses 1, 2, 6 and 7 read as 0.
- R8: `irq` is high in the same cycle whenever any bit is set in both the mask and the status word.
- R9: After reset both watermarks are 1, the mask is 0, the latched events are 0 and `irq` is low.
- R10: A write to address 4 loads the transmit watermark, and a write to address 5 loads the receive watermark, each from `reg_wdata[5:0]`. Each reads back zero-extended at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| tx_count | input | 6 | Transmit FIFO occupancy |
| rx_count | input | 6 | Receive FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| ev_tx_underflow | input | 1 | Transmit underflow event pulse |
| ev_rx_overflow | input | 1 | Receive overflow event pulse |
| ev_mode_fail | input | 1 | Mode fail event pulse |
| irq | output | 1 | Level interrupt output |

## Verification
The watermark comparisons are driven with counts just below, equal to and just above each watermark, and with watermarks of 0 and 32. These cases show whether the compare is `>=` or `<` and whether it is inclusive at the boundary. The latched events are pulsed alone, then cleared with data of zero, then cleared with data of one, and also pulsed in the same cycle as a clear. These cases tell persistence, clearing and the event-wins rule apart. Enable and disable writes with overlapping bit sets separate OR-in behaviour from direct loading of the mask. A long run of random counts, events and writes is compared every cycle against a behavioural model, with FIFO counts and full flags kept consistent with each other.

// File: rtl/spi_irq_regs.sv
module spi_irq_regs #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int AW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  input  logic          tx_full,
  input  logic          rx_full,
  input  logic          ev_tx_underflow,
  input  logic          ev_rx_overflow,
  input  logic          ev_mode_fail,
  output logic          irq
);
  localparam int NB = 7;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_EN   = AW'(1);
  localparam logic [AW-1:0] A_DIS  = AW'(2);
  localparam logic [AW-1:0] A_MASK = AW'(3);
  localparam logic [AW-1:0] A_TXT  = AW'(4);
  localparam logic [AW-1:0] A_RXT  = AW'(5);
  localparam int B_TXUF = 6;
  localparam int B_RXF  = 5;
  localparam int B_RXNE = 4;
  localparam int B_TXF  = 3;
  localparam int B_TXNF = 2;
  localparam int B_MF   = 1;
  localparam int B_RXOV = 0;

  logic          uf_q, mf_q, ov_q;
  logic [NB-1:0] mask_q;
  logic [CW-1:0] tx_thr_q, rx_thr_q;
  logic [NB-1:0] status_w;

  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire wr_en   = reg_wr && reg_addr == A_EN;
  wire wr_dis  = reg_wr && reg_addr == A_DIS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uf_q     <= 1'b0;
      mf_q     <= 1'b0;
      ov_q     <= 1'b0;
      mask_q   <= '0;
      tx_thr_q <= CW'(1);
      rx_thr_q <= CW'(1);
    end else begin
      uf_q <= ev_tx_underflow | (uf_q & ~(wr_stat & reg_wdata[B_TXUF]));
      mf_q <= ev_mode_fail    | (mf_q & ~(wr_stat & reg_wdata[B_MF]));
      ov_q <= ev_rx_overflow  | (ov_q & ~(wr_stat & reg_wdata[B_RXOV]));
      if (wr_en)  mask_q <= mask_q | reg_wdata[NB-1:0];
      if (wr_dis) mask_q <= mask_q & ~reg_wdata[NB-1:0];
      if (reg_wr && reg_addr == A_TXT) tx_thr_q <= reg_wdata[CW-1:0];
      if (reg_wr && reg_addr == A_RXT) rx_thr_q <= reg_wdata[CW-1:0];
    end
  end

  assign status_w = {uf_q, rx_full, rx_count >= rx_thr_q, tx_full,
                     tx_count < tx_thr_q, mf_q, ov_q};

  assign irq = |(mask_q & status_w);

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = DW'(status_w);
      A_MASK:  reg_rdata = DW'(mask_q);
      A_TXT:   reg_rdata = DW'(tx_thr_q);
      A_RXT:   reg_rdata = DW'(rx_thr_q);
      default: reg_rdata = '0;
    endcase
  end

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mode_fail |=> status_w[B_MF]);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[B_RXOV] && !ev_rx_overflow) |=> !status_w[B_RXOV]);
  p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_tx_underflow && wr_stat && reg_wdata[B_TXUF]) |=> status_w[B_TXUF]);
  p_rx_zero_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_thr_q == '0) |-> status_w[B_RXNE]);
  p_tx_zero_thr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_thr_q == '0) |-> !status_w[B_TXNF]);
  p_full_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[B_RXF] == rx_full && status_w[B_TXF] == tx_full);
  p_mask_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mask_q & $past(reg_wdata[NB-1:0])) == $past(reg_wdata[NB-1:0]));
  p_mask_dis_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dis |=> (mask_q & $past(reg_wdata[NB-1:0])) == '0);
  p_irq_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: tb/spi_irq_regs_tb_top.sv
module spi_irq_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] tx_count = '0, rx_count = '0;
  logic       tx_full = 1'b0, rx_full = 1'b0;
  logic       ev_u = 1'b0, ev_o = 1'b0, ev_m = 1'b0;
  logic       irq;

  int checks = 0, fails = 0;
  int m_u, m_o, m_m, m_mask, m_txt, m_rxt;

  always #4 clk = ~clk;

  spi_irq_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_count(tx_count),
    .rx_count(rx_count), .tx_full(tx_full), .rx_full(rx_full),
    .ev_tx_underflow(ev_u), .ev_rx_overflow(ev_o), .ev_mode_fail(ev_m),
    .irq(irq)
  );

  function automatic int exp_status();
    int rxne = (int'(rx_count) >= m_rxt) ? 1 : 0;
    int txnf = (int'(tx_count) < m_txt) ? 1 : 0;
    return (m_u << 6) | (int'(rx_full) << 5) | (rxne << 4) |
           (int'(tx_full) << 3) | (txnf << 2) | (m_m << 1) | m_o;
  endfunction

  function automatic int exp_rdata();
    case (reg_addr)
      3'd0: return exp_status();
      3'd3: return m_mask;
      3'd4: return m_txt;
      3'd5: return m_rxt;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag);
    int st;
    #1;
    st = exp_status();
    check({tag, " rdata"}, int'(reg_rdata), exp_rdata());
    check({tag, " irq R8"}, int'(irq), ((m_mask & st) != 0) ? 1 : 0);
    @(posedge clk);
    if (reg_wr) begin
      case (reg_addr)
        3'd0: begin
          if (reg_wdata[6]) m_u = 0;
          if (reg_wdata[1]) m_m = 0;
          if (reg_wdata[0]) m_o = 0;
        end
        3'd1: m_mask = m_mask | (int'(reg_wdata) & 'h7f);
        3'd2: m_mask = m_mask & ~(int'(reg_wdata) & 'h7f);
        3'd4: m_txt = int'(reg_wdata) & 'h3f;
        3'd5: m_rxt = int'(reg_wdata) & 'h3f;
        default: ;
      endcase
    end
    if (ev_u) m_u = 1;
    if (ev_o) m_o = 1;
    if (ev_m) m_m = 1;
    @(negedge clk);
    reg_wr = 1'b0; ev_u = 1'b0; ev_o = 1'b0; ev_m = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    reg_addr = 3'(a);
    step(tag);
  endtask

  task automatic wr(input int a, input int d, input string tag);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    step(tag);
  endtask

  task automatic fifo(input int t, input int r);
    tx_count = 6'(t); rx_count = 6'(r);
    tx_full = (t == 32); rx_full = (r == 32);
  endtask

  initial begin
    m_u = 0; m_o = 0; m_m = 0; m_mask = 0; m_txt = 1; m_rxt = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(4, "R9 tx watermark");
    rd(5, "R9 rx watermark");
    rd(3, "R9 mask");
    rd(0, "R9 R1 status");
    // R4 receive watermark boundaries
    wr(5, 5, "R10 load rx watermark");
    fifo(0, 4); rd(0, "R4 below");
    fifo(0, 5); rd(0, "R4 equal");
    fifo(0, 6); rd(0, "R4 above");
    wr(5, 0, "R4 watermark 0");
    fifo(0, 0); rd(0, "R4 zero");
    wr(5, 32, "R10 rx 32");
    fifo(0, 32); rd(0, "R4 R6 full at 32");
    rd(5, "R10 readback");
    // R5 transmit watermark boundaries
    wr(4, 8, "R10 load tx watermark");
    fifo(7, 0); rd(0, "R5 below");
    fifo(8, 0); rd(0, "R5 equal");
    fifo(9, 0); rd(0, "R5 above");
    wr(4, 0, "R5 watermark 0");
    fifo(0, 0); rd(0, "R5 zero");
    wr(4, 1, "R10 restore tx"); wr(5, 1, "R10 restore rx");
    // R6 live full flags
    fifo(32, 32);
    wr(0, 'h7f, "R6 clear write"); rd(0, "R6 still full");
    fifo(3, 3); rd(0, "R6 dropped");
    // R2 sticky events
    ev_u = 1'b1; rd(0, "R2 pulse underflow");
    ev_m = 1'b1; rd(0, "R2 pulse mode fail");
    ev_o = 1'b1; rd(0, "R2 pulse overflow");
    rd(0, "R2 held");
    wr(0, 0, "R2 write zero"); rd(0, "R2 after zero");
    wr(0, 'h01, "R2 clear ovf"); rd(0, "R2 after clear");
    // R3 event wins over clear
    ev_m = 1'b1; wr(0, 'h42, "R3 collide"); rd(0, "R3 result");
    // R7 mask manipulation, R8 interrupt
    wr(1, 'h41, "R7 enable"); rd(3, "R7 mask read"); rd(0, "R8 irq on");
    wr(1, 'h02, "R7 enable or"); rd(3, "R7 mask or");
    wr(2, 'h40, "R7 disable"); rd(3, "R7 after disable");
    wr(3, 'h7f, "R7 direct write"); rd(3, "R7 ignored");
    rd(1, "R7 enable reads zero"); rd(2, "R7 disable reads zero");
    rd(6, "R7 spare zero");
    wr(0, 'h43, "R2 clear all"); wr(2, 'h7f, "R7 clear mask");
    rd(0, "R8 irq off");
    // random sweep against the model
    for (int i = 0; i < 3000; i++) begin
      int t = $urandom_range(0, 32);
      int r = $urandom_range(0, 32);
      fifo(t, r);
      ev_u = ($urandom_range(0, 15) == 0);
      ev_o = ($urandom_range(0, 15) == 0);
      ev_m = ($urandom_range(0, 15) == 0);
      reg_addr = 3'($urandom_range(0, 7));
      reg_wr = ($urandom_range(0, 3) == 0);
      reg_wdata = 8'($urandom_range(0, 255));
      if (reg_addr >= 4) reg_wdata = 8'($urandom_range(0, 33));
      step("R1 R2 R4 R5 R7 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule